// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of the two-wire serial management bus that reaches external Ethernet PHY devices. A host presents one request at a time. Each request carries a frame-format select (Clause 22 or Clause 45), a two-bit opcode, two five-bit address fields and a sixteen-bit data word. The block turns the request into a 65-bit frame. It drives the management clock (MDC) and the data line through a separate output value and output enable, and it samples the line on read frames. When the frame ends it raises a one-cycle completion pulse, and on a read the captured word is on the read-data port.

MDC comes from the system clock. Each MDC period lasts two half periods of `cfg_half_div` system cycles. The default bench setting is 10, which gives 2.5 MHz from a 50 MHz system clock. Two small offsets adjust the line timing. The hold offset delays the point where the master changes the data line after MDC falls. The capture offset delays the point where the master samples the line after MDC rises. All three settings are latched when a request is accepted. Both offsets must be smaller than `cfg_half_div`.

The controller is a six-state machine:
- `ST_IDLE` waits for a legal request and moves to `ST_PRE` when it accepts one.
- `ST_PRE` sends bits 0 to 31 and moves to `ST_HDR` at the end of bit 31.
- `ST_HDR` sends the start, opcode and address fields (bits 32 to 45) and moves to `ST_TURN` at the end of bit 45.
- `ST_TURN` handles the two turnaround bits (46 and 47) and moves to `ST_DATA`.
- `ST_DATA` sends or receives bits 48 to 63 and moves to `ST_TAIL`.
- `ST_TAIL` is the released bit 64. It returns to `ST_IDLE` and raises the completion pulse.

A request with an illegal opcode never leaves `ST_IDLE`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `req_err`, `mdc`, `mdio_o` and `mdio_oe` are low and `rd_data` is zero.
- R2: Every frame is 65 MDC periods long. Its first 32 bits are ones, driven with `mdio_oe` high.
- R3: With `req_c45`=0, bits 32-33 are 01, bits 34-35 are `req_op` (10 is read, 01 is write), bits 36-40 are `req_port` MSB first and bits 41-45 are `req_dev` MSB first.
- R4: With `req_c45`=1, bits 32-33 are 00 and bits 34-35 are `req_op`: 00 is address, 01 is write, 11 is read and 10 is read with post-increment. The two address fields follow as in R3.
- R5: On write and address frames, bits 46-47 are driven as 1 then 0. On read frames (Clause 22 opcode 10, Clause 45 opcodes 11 and 10), `mdio_oe` is low from bit 46 through bit 64.
- R6: On non-read frames, bits 48-63 carry `req_wdata` MSB first. On read frames these bits are captured MSB first into `rd_data`. A non-read frame leaves `rd_data` at zero.
- R7: Bit 64 has `mdio_oe` low. `busy` stays high for exactly 130×`cfg_half_div` system cycles per frame.
- R8: During a frame, each bit holds `mdc` low for `cfg_half_div` cycles and then high for `cfg_half_div` cycles. `mdc` is low whenever `busy` is low.
- R9: `mdio_o` and `mdio_oe` change only `cfg_hold`+1 cycles after MDC falls. For the first bit, that count starts from acceptance.
- R10: `mdio_i` is sampled at the clock edge that ends the cycle `cfg_capture` cycles after the first MDC-high cycle, where the first high cycle is number 0.
- R11: A request is accepted only while `busy` is low, and requests made while busy are ignored. `done` is high for one cycle, in the first cycle with `busy` low after a frame.
- R12: A request with `req_c45`=0 and opcode 00 or 11 raises `req_err` for one cycle in the next cycle. It starts no frame: `busy` and `mdc` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; taken when `busy` is low |
| req_c45 | input | 1 | 1 selects the Clause 45 frame format |
| req_op | input | 2 | Opcode placed in the frame |
| req_port | input | 5 | PHY or port address |
| req_dev | input | 5 | Register or MMD device address |
| req_wdata | input | 16 | Write data, or the register address on a Clause 45 address frame |
| cfg_half_div | input | DIV_W | System cycles per MDC half period |
| cfg_hold | input | OFS_W | Output hold offset in cycles |
| cfg_capture | input | OFS_W | Input capture offset in cycles |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle illegal-request pulse |
| rd_data | output | 16 | Data captured by the last completed frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench models the PHY in a strict mode: the correct read bit appears only in the single cycle that R10 names, and the inverted bit appears in every other cycle. A capture offset off by one cycle therefore returns an inverted read word. Every frame is rebuilt bit by bit at the MDC rising edges and compared with a scoreboard entry. A wrong start field, a swapped address field, or a turnaround that drives the line on a read shows up as a bit mismatch. The MDC half periods and the cycle of every line change are timed, so an off-by-one divider or hold offset is caught. This is also run at the smallest divider of 1 and at the largest offsets of 7. Requests made while busy and illegal Clause 22 opcodes are checked: any extra frame, any MDC activity or any missing error pulse is reported.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LAST  = 31;
    localparam int HDR_LAST  = 45;
    localparam int TURN_LAST = 47;
    localparam int DATA_LAST = 63;
    localparam int FRAME_W   = 32;
    localparam int WORD_W    = 16;
    localparam int ADR_W     = 5;
    localparam int CNT_W     = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_TAIL
    } mdio_state_e;

    function automatic logic op_reads(input logic c45, input logic [1:0] op);
        return c45 ? op[1] : (op == 2'b10);
    endfunction

    function automatic logic op_legal(input logic c45, input logic [1:0] op);
        return c45 || (op == 2'b01) || (op == 2'b10);
    endfunction

endpackage

// File: rtl/mdio_req_check.sv
module mdio_req_check
    import mdio_pkg::*;
(
    input  logic                 c45,
    input  logic [1:0]           op,
    input  logic [ADR_W-1:0]     port_adr,
    input  logic [ADR_W-1:0]     dev_adr,
    input  logic [WORD_W-1:0]    wdata,
    output logic                 legal,
    output logic                 is_read,
    output logic [FRAME_W-1:0]   tx_word
);
    logic [1:0] start_bits;

    always_comb begin
        legal      = op_legal(c45, op);
        is_read    = op_reads(c45, op);
        start_bits = c45 ? 2'b00 : 2'b01;
        tx_word    = {start_bits, op, port_adr, dev_adr, 2'b10, wdata};
    end
endmodule

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
    parameter int DIV_W = 8,
    parameter int OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    input  logic [OFS_W-1:0] hold,
    input  logic [OFS_W-1:0] cap,
    output logic             mdc,
    output logic             launch,
    output logic             sample,
    output logic             bit_end
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_last;
    logic [PH_W-1:0] ph_rise_m1;
    logic [PH_W-1:0] ph_hold;
    logic [PH_W-1:0] ph_cap;

    always_comb begin
        ph_last    = {half, 1'b0} - PH_W'(1);
        ph_rise_m1 = PH_W'(half) - PH_W'(1);
        ph_hold    = PH_W'(hold);
        ph_cap     = PH_W'(half) + PH_W'(cap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            ph  <= '0;
            mdc <= 1'b0;
        end else if (ph == ph_last) begin
            ph  <= '0;
            mdc <= 1'b0;
        end else begin
            ph <= ph + PH_W'(1);
            if (ph == ph_rise_m1) begin
                mdc <= 1'b1;
            end
        end
    end

    assign launch  = run && (ph == ph_hold);
    assign sample  = run && (ph == ph_cap);
    assign bit_end = run && (ph == ph_last);

    a_r9_launch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !mdc);
    a_r10_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> mdc);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OFS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_c45,
    input  logic [1:0]        req_op,
    input  logic [4:0]        req_port,
    input  logic [4:0]        req_dev,
    input  logic [15:0]       req_wdata,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [OFS_W-1:0]  cfg_hold,
    input  logic [OFS_W-1:0]  cfg_capture,
    output logic              busy,
    output logic              done,
    output logic              req_err,
    output logic [15:0]       rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_state_e state, state_n;

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] tx_sr;
    logic               rd_q;
    logic [DIV_W-1:0]   half_q;
    logic [OFS_W-1:0]   hold_q;
    logic [OFS_W-1:0]   cap_q;

    logic               legal, is_read;
    logic [FRAME_W-1:0] tx_word;
    logic               launch, sample, bit_end;
    logic               accept, reject;
    logic [WORD_W-1:0]  rx_word;

    mdio_req_check u_check (
        .c45      (req_c45),
        .op       (req_op),
        .port_adr (req_port),
        .dev_adr  (req_dev),
        .wdata    (req_wdata),
        .legal    (legal),
        .is_read  (is_read),
        .tx_word  (tx_word)
    );

    mdio_bit_timer #(.DIV_W(DIV_W), .OFS_W(OFS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .half    (half_q),
        .hold    (hold_q),
        .cap     (cap_q),
        .mdc     (mdc),
        .launch  (launch),
        .sample  (sample),
        .bit_end (bit_end)
    );

    mdio_rx_shift #(.W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (sample && (state == ST_DATA) && rd_q),
        .din      (mdio_i),
        .q        (rx_word)
    );

    assign busy   = (state != ST_IDLE);
    assign accept = req_valid && !busy && legal;
    assign reject = req_valid && !busy && !legal;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = ST_PRE;
            ST_PRE:  if (bit_end && bit_cnt == CNT_W'(PRE_LAST))  state_n = ST_HDR;
            ST_HDR:  if (bit_end && bit_cnt == CNT_W'(HDR_LAST))  state_n = ST_TURN;
            ST_TURN: if (bit_end && bit_cnt == CNT_W'(TURN_LAST)) state_n = ST_DATA;
            ST_DATA: if (bit_end && bit_cnt == CNT_W'(DATA_LAST)) state_n = ST_TAIL;
            ST_TAIL: if (bit_end) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
            rd_q    <= 1'b0;
            half_q  <= '0;
            hold_q  <= '0;
            cap_q   <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            req_err <= 1'b0;
            rd_data <= '0;
        end else begin
            done    <= 1'b0;
            req_err <= reject;
            if (accept) begin
                tx_sr   <= tx_word;
                rd_q    <= is_read;
                half_q  <= cfg_half_div;
                hold_q  <= cfg_hold;
                cap_q   <= cfg_capture;
                bit_cnt <= '0;
            end
            if (bit_end) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (launch) begin
                unique case (state)
                    ST_PRE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                    ST_HDR: begin
                        mdio_o  <= tx_sr[FRAME_W-1];
                        mdio_oe <= 1'b1;
                        tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                    ST_TURN, ST_DATA: begin
                        mdio_o  <= tx_sr[FRAME_W-1];
                        mdio_oe <= !rd_q;
                        tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                    ST_TAIL: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (bit_end && state == ST_TAIL) begin
                done    <= 1'b1;
                rd_data <= rd_q ? rx_word : '0;
            end
        end
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r12_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !busy);
    a_r8_mdc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && rd_q) |-> !mdio_oe);
    a_r7_tail_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int DIV_W = 8;
    localparam int OFS_W = 3;

    typedef struct {
        logic [64:0] oe;
        logic [64:0] o;
        logic [15:0] rd;
        int          half;
    } exp_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_c45 = 1'b0;
    logic [1:0] req_op = '0;
    logic [4:0] req_port = '0, req_dev = '0;
    logic [15:0] req_wdata = '0;
    logic [DIV_W-1:0] cfg_half_div = 8'd10;
    logic [OFS_W-1:0] cfg_hold = '0, cfg_capture = '0;
    logic busy, done, req_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic mdio_i = 1'b1;

    mdio_master #(.DIV_W(DIV_W), .OFS_W(OFS_W)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_c45(req_c45),
        .req_op(req_op), .req_port(req_port), .req_dev(req_dev),
        .req_wdata(req_wdata), .cfg_half_div(cfg_half_div), .cfg_hold(cfg_hold),
        .cfg_capture(cfg_capture), .busy(busy), .done(done), .req_err(req_err),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int checks = 0, failures = 0, done_cnt = 0, total_rises = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    logic cur_read = 1'b0, strict = 1'b0;
    logic [15:0] cur_rdv = '0;
    int cur_cap = 0, cur_half = 10, cur_hold = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic exp_t build(input logic c45, input logic [1:0] op, input logic [4:0] pa,
                                   input logic [4:0] da, input logic [15:0] wd, input logic [15:0] rdv);
        exp_t e;
        logic rd;
        logic [13:0] hdr;
        rd  = c45 ? op[1] : (op == 2'b10);
        hdr = {(c45 ? 2'b00 : 2'b01), op, pa, da};
        e.oe = '0;
        e.o  = '0;
        e.rd = rd ? rdv : 16'h0;
        e.half = int'(cfg_half_div);
        for (int k = 0; k < 65; k++) begin
            if (k < 32) begin
                e.oe[k] = 1'b1; e.o[k] = 1'b1;
            end else if (k < 46) begin
                e.oe[k] = 1'b1; e.o[k] = hdr[45-k];
            end else if (k < 48) begin
                e.oe[k] = !rd; e.o[k] = (k == 46);
            end else if (k < 64) begin
                e.oe[k] = !rd; e.o[k] = wd[63-k];
            end
        end
        return e;
    endfunction

    // Monitor and PHY model
    logic prev_mdc = 0, prev_o = 0, prev_oe = 0, prev_busy = 0;
    int rises = 0, since_fall = 0, low_run = 0, high_run = 0, cap_cnt = 0;
    int hold_bad = 0, mdc_bad = 0, busy_cycles = 0;
    logic [64:0] got_oe, got_o;

    always @(negedge clk) begin
        exp_t e;
        logic bitv;
        int k;
        if (busy && !prev_busy) begin
            rises = 0; since_fall = 0; low_run = 0; high_run = 0;
            hold_bad = 0; mdc_bad = 0; busy_cycles = 0;
            got_oe = '0; got_o = '0;
        end else if (prev_mdc && !mdc) begin
            since_fall = 0;
        end else begin
            since_fall++;
        end
        if (busy) busy_cycles++;
        if (busy && ((mdio_o != prev_o) || (mdio_oe != prev_oe)) && since_fall != cur_hold + 1)
            hold_bad++;
        if (mdc && !prev_mdc) begin
            if (low_run != cur_half) mdc_bad++;
            if (rises < 65) begin
                got_oe[rises] = mdio_oe;
                got_o[rises]  = mdio_o;
            end
            rises++; total_rises++;
            high_run = 1; cap_cnt = 0;
        end else if (mdc) begin
            high_run++; cap_cnt++;
        end
        if (!mdc && prev_mdc) begin
            if (high_run != cur_half) mdc_bad++;
            low_run = busy ? 1 : 0;
        end else if (!mdc && busy) begin
            low_run++;
        end
        // PHY drive for this cycle
        mdio_i = 1'b1;
        if (busy && cur_read && rises >= 1) begin
            k = rises - 1;
            bitv = 1'b1;
            if (k == 47) bitv = 1'b0;
            else if (k >= 48 && k <= 63) bitv = cur_rdv[63-k];
            if (strict && !(mdc && cap_cnt == cur_cap)) mdio_i = ~bitv;
            else mdio_i = bitv;
        end
        if (done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected frame completion", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(rises == 65, "R2 R7 frame bit count", 64'(rises), 65);
                check(busy_cycles == 130 * e.half, "R7 busy duration", 64'(busy_cycles), 64'(130 * e.half));
                check(got_oe == e.oe, "R2 R5 R7 output enable pattern", 64'(got_oe[64:1]), 64'(e.oe[64:1]));
                check(((got_o ^ e.o) & e.oe) == '0, "R2 R3 R4 R5 R6 driven bits", 64'(got_o[63:0]), 64'(e.o[63:0]));
                check(rd_data == e.rd, "R6 R10 read data", 64'(rd_data), 64'(e.rd));
                check(hold_bad == 0, "R9 line change timing", 64'(hold_bad), 0);
                check(mdc_bad == 0, "R8 MDC half periods", 64'(mdc_bad), 0);
                check(!busy, "R11 done with busy low", 64'(busy), 0);
            end
            done_cnt++;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_busy = busy;
    end

    task automatic run_frame(input logic c45, input logic [1:0] op, input logic [4:0] pa,
                             input logic [4:0] da, input logic [15:0] wd, input logic [15:0] rdv);
        int prev;
        while (busy) @(negedge clk);
        cur_read = c45 ? op[1] : (op == 2'b10);
        cur_rdv  = rdv;
        cur_half = int'(cfg_half_div);
        cur_hold = int'(cfg_hold);
        cur_cap  = int'(cfg_capture);
        exp_q.push_back(build(c45, op, pa, da, wd, rdv));
        prev = done_cnt;
        req_c45 = c45; req_op = op; req_port = pa; req_dev = da; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R11 accepted when idle", 64'(busy), 1);
        while (done_cnt == prev) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R11 done lasts one cycle", 64'(done), 0);
    endtask

    task automatic set_timing(input int h, input int ho, input int ca, input bit st);
        cfg_half_div = DIV_W'(h);
        cfg_hold     = OFS_W'(ho);
        cfg_capture  = OFS_W'(ca);
        strict       = st;
    endtask

    initial begin
        int prev, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !req_err, "R1 control outputs at reset", {busy, done, req_err}, 0);
        check(!mdc && !mdio_o && !mdio_oe, "R1 line outputs at reset", {mdc, mdio_o, mdio_oe}, 0);
        check(rd_data == 16'h0, "R1 read data at reset", 64'(rd_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Clause 22 at default timing
        set_timing(10, 0, 0, 1'b0);
        run_frame(1'b0, 2'b01, 5'h01, 5'h1F, 16'hBEEF, 16'h0);   // R3 write
        run_frame(1'b0, 2'b10, 5'h15, 5'h0A, 16'h0000, 16'hA5C3); // R3 R6 read

        // Clause 45 with strict capture window, R4 R10
        set_timing(4, 3, 2, 1'b1);
        run_frame(1'b1, 2'b00, 5'h1E, 5'h03, 16'h8001, 16'h0);    // address
        run_frame(1'b1, 2'b01, 5'h1E, 5'h03, 16'h1234, 16'h0);    // write
        run_frame(1'b1, 2'b11, 5'h02, 5'h1D, 16'h0000, 16'h6E91); // read
        run_frame(1'b1, 2'b10, 5'h02, 5'h1D, 16'h0000, 16'h0F0F); // read post-increment

        // Smallest divider, R8 R9 R10
        set_timing(1, 0, 0, 1'b1);
        run_frame(1'b0, 2'b10, 5'h00, 5'h11, 16'h0, 16'hC0DE);
        run_frame(1'b0, 2'b01, 5'h1F, 5'h00, 16'h5A5A, 16'h0);

        // Largest offsets, R9 R10
        set_timing(9, 7, 7, 1'b1);
        run_frame(1'b1, 2'b11, 5'h0C, 5'h07, 16'h0, 16'h7FFE);
        run_frame(1'b0, 2'b01, 5'h0C, 5'h07, 16'hFFFF, 16'h0);

        // R11 requests while busy are ignored
        set_timing(3, 1, 1, 1'b0);
        cur_read = 1'b0; cur_half = 3; cur_hold = 1; cur_cap = 1;
        exp_q.push_back(build(1'b0, 2'b01, 5'h04, 5'h05, 16'h0A0A, 16'h0));
        prev = done_cnt;
        req_c45 = 1'b0; req_op = 2'b01; req_port = 5'h04; req_dev = 5'h05; req_wdata = 16'h0A0A;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_c45 = 1'b1; req_op = 2'b11; req_port = 5'h1B; req_dev = 5'h1B; req_wdata = 16'hFFFF;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == prev) @(negedge clk);
        repeat (60) @(negedge clk);
        check(done_cnt == prev + 1, "R11 busy request started no frame", 64'(done_cnt - prev), 1);
        check(!busy && !mdc, "R11 idle after ignored request", {busy, mdc}, 0);
        check(exp_q.size() == 0, "R11 scoreboard drained", 64'(exp_q.size()), 0);

        // R12 illegal Clause 22 opcodes
        for (int t = 0; t < 2; t++) begin
            r0 = total_rises;
            req_c45 = 1'b0; req_op = (t == 0) ? 2'b00 : 2'b11;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(req_err == 1'b1, "R12 error pulse raised", 64'(req_err), 1);
            check(busy == 1'b0, "R12 no frame started", 64'(busy), 0);
            @(negedge clk);
            check(req_err == 1'b0, "R12 error pulse one cycle", 64'(req_err), 0);
            repeat (30) @(negedge clk);
            check(!busy && total_rises == r0, "R12 MDC stayed quiet", 64'(total_rises - r0), 0);
        end

        // Back to normal after errors
        set_timing(10, 2, 3, 1'b1);
        run_frame(1'b0, 2'b10, 5'h09, 5'h02, 16'h0, 16'h8421);
        summary();
    end

    int wd_cyc = 0;
    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc >= 190000 && !finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd_cyc, 0);
            summary();
        end
    end
endmodule